// File: doc/BRIEF.md
# DMA Command Strobe Timing Generator

This block generates the four active-low command strobes of one DMA transfer: memory read, memory write, I/O read and I/O write. A one-cycle start pulse begins a transfer. A direction input selects which read strobe and which write strobe are used. A width input selects which of two programmable wait-state fields sets the length of the command. The arbitration, address and count logic sit outside the block and supply the start, direction and width inputs.

All timing is counted in DMA clocks, which are derived from the bus clock. One DMA clock lasts two bus clocks or one bus clock, selected by configuration. The write command stays low for the programmed wait count plus one DMA clock. While the count runs out, a low ready input keeps the command low for further DMA clocks. The memory-read strobe can start either together with the other strobes or one DMA clock after them. When all strobes are high again, the block raises a done pulse for one clock.

Top module: `dma_cmd_timer`

## Requirements
- R1: After reset, all four strobes are high, and busy and done are low.
- R2: With mem_to_io=1, memr_n and iow_n are driven and ior_n and memw_n stay high. With mem_to_io=0, ior_n and memw_n are driven and memr_n and iow_n stay high. The driven write strobe, and ior_n, go low in the first clock after the start edge.
- R3: A wait field value f (2 bits) gives W=f+1 wait states. With ready high, the write strobe stays low for exactly (W+1) DMA clocks, so it is never shorter than two DMA clocks.
- R4: wide=1 takes the wait field from cfg[5:4]. wide=0 takes it from cfg[3:2].
- R5: cfg[0]=0 makes one DMA clock last D=2 bus clocks. cfg[0]=1 makes it last D=1 bus clock.
- R6: With cfg[1]=0, memr_n goes low D bus clocks after the write strobe does. With cfg[1]=1, memr_n goes low together with the write strobe. In both settings memr_n rises together with the write strobe.
- R7: Ready is sampled at DMA clock edges once the count has expired. If ready first reads high at bus edge r after the start edge, the write low time is D*max(W+1, ceil(r/D)) bus clocks.
- R8: done is high for exactly one clock: the first clock in which all strobes are high again. busy is low in that clock.
- R9: A start pulse while busy is ignored. cfg, mem_to_io and wide are captured at the start edge, so later changes to them do not affect the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg | input | 6 | [5:4] 16-bit wait field, [3:2] 8-bit wait field, [1] memory-read no-delay, [0] fast DMA clock |
| start | input | 1 | One-cycle transfer request |
| mem_to_io | input | 1 | 1: memory to I/O, 0: I/O to memory |
| wide | input | 1 | 1: 16-bit transfer, 0: 8-bit transfer |
| ready | input | 1 | Low stretches the command |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock end-of-transfer pulse |

## Verification
Each strobe is registered once after the start edge, so the bench indexes every falling clock edge after the start pulse. Index 1 is the first clock in which a strobe can be low. The bench counts low cycles and records the first low index for each strobe, and compares them with (W+1)*D and with offset D+1 for a delayed memory read. done is due at index L+1, where L is the computed write low time. For ready stalls, the bench raises ready at a known index r and predicts the end at the next DMA clock boundary at or after both r and (W+1)*D.

// File: rtl/dma_cmd_timer.sv
module dma_cmd_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] cfg,
  input  logic       start,
  input  logic       mem_to_io,
  input  logic       wide,
  input  logic       ready,
  output logic       memr_n,
  output logic       memw_n,
  output logic       ior_n,
  output logic       iow_n,
  output logic       busy,
  output logic       done
);
  logic       ph, fast_q, dir_q, memr_on;
  logic [2:0] cnt;
  logic       tick;

  assign tick = busy & (fast_q | ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      ph      <= 1'b0;
      fast_q  <= 1'b0;
      dir_q   <= 1'b0;
      memr_on <= 1'b0;
      cnt     <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          ph      <= 1'b0;
          fast_q  <= cfg[0];
          dir_q   <= mem_to_io;
          memr_on <= cfg[1];
          cnt     <= {1'b0, (wide ? cfg[5:4] : cfg[3:2])} + 3'd1;
        end
      end else begin
        ph <= ~ph;
        if (tick) begin
          memr_on <= 1'b1;
          if (cnt != 3'd0) cnt <= cnt - 3'd1;
          else if (ready) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            memr_on <= 1'b0;
          end
        end
      end
    end
  end

  assign iow_n  = ~(busy & dir_q);
  assign memr_n = ~(busy & dir_q & memr_on);
  assign ior_n  = ~(busy & ~dir_q);
  assign memw_n = ~(busy & ~dir_q);

  AST_MEMR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n) !memr_n |-> !iow_n); // R6
  AST_IOR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n) !ior_n |-> !memw_n); // R2
  AST_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(iow_n & memw_n) |=> !(iow_n & memw_n)); // R3
  AST_END_READY: assert property (@(posedge clk) disable iff (!rst_n) $rose(iow_n & memw_n) |-> $past(ready)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) done |-> (memr_n & memw_n & ior_n & iow_n & !busy)); // R8
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R9
endmodule

// File: tb/dma_cmd_timer_tb.sv
module dma_cmd_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] cfg = '0;
  logic start = 1'b0, mem_to_io = 1'b0, wide = 1'b0, ready = 1'b1;
  logic memr_n, memw_n, ior_n, iow_n, busy, done;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  dma_cmd_timer dut_i (.clk(clk), .rst_n(rst_n), .cfg(cfg), .start(start),
    .mem_to_io(mem_to_io), .wide(wide), .ready(ready), .memr_n(memr_n),
    .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n), .busy(busy), .done(done));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [5:0] c, input logic dir, input logic wd, input int r);
    int d, w, l, rdfirst, rdlen, wrfirst, wrlen, unused, dcount, didx, rdelay, busy_at_done;
    d = c[0] ? 1 : 2;
    w = (wd ? int'(c[5:4]) : int'(c[3:2])) + 1;
    l = w + 1;
    if (r > 0 && (r + d - 1) / d > l) l = (r + d - 1) / d;
    l = l * d;
    rdelay = c[1] ? 0 : d;
    rdfirst = 0; rdlen = 0; wrfirst = 0; wrlen = 0; unused = 0; dcount = 0; didx = 0; busy_at_done = 1;
    @(negedge clk);
    cfg = c; mem_to_io = dir; wide = wd; start = 1'b1; ready = (r > 0) ? 1'b0 : 1'b1;
    for (int i = 1; i <= 40; i++) begin
      logic rdl, wrl;
      @(negedge clk);
      rdl = dir ? !memr_n : !ior_n;
      wrl = dir ? !iow_n : !memw_n;
      if (rdl) begin rdlen++; if (rdfirst == 0) rdfirst = i; end
      if (wrl) begin wrlen++; if (wrfirst == 0) wrfirst = i; end
      if (dir ? (!ior_n || !memw_n) : (!memr_n || !iow_n)) unused++;
      if (done) begin dcount++; didx = i; busy_at_done = busy; end
      start = (i == 2);
      if (i == 1) cfg = ~c;
      if (i == 1) wide = ~wd;
      if (i == 1) mem_to_io = ~dir;
      if (r > 0 && i == r) ready = 1'b1;
    end
    start = 1'b0;
    chk(r > 0 ? "R7 write low time with stall" : "R3/R4/R5 write low time", wrlen, l);
    chk("R2 write first low", wrfirst, 1);
    chk("R2 unused strobes", unused, 0);
    if (dir) begin
      chk("R6 memr first low", rdfirst, 1 + rdelay);
      chk("R6 memr low time", rdlen, l - rdelay);
    end else begin
      chk("R2 ior first low", rdfirst, 1);
      chk("R2 ior low time", rdlen, l);
    end
    chk("R8 done count", dcount, 1);
    chk("R8 done index", didx, l + 1);
    chk("R8 busy at done", int'(busy_at_done), 0);
    chk("R9 no second transfer", int'(busy), 0);
  endtask

  initial begin
    #20000000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk("R1 reset strobes", int'({memr_n, memw_n, ior_n, iow_n}), 15);
    chk("R1 reset busy/done", int'({busy, done}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'({memr_n, memw_n, ior_n, iow_n, busy, done}), 60);
    for (int c = 0; c < 64; c++)
      for (int k = 0; k < 4; k++)
        run(6'(c), k[0], k[1], 0);
    for (int c = 0; c < 64; c += 5)
      for (int r = 1; r <= 14; r += 3)
        run(6'(c), c[2], c[3], r);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule